// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns a parallel data word into one asynchronous serial frame on a single line. A start strobe, accepted while the block is idle, captures the data input and a 7-bit format control word. The frame is then shifted out one bit per baud tick: a low start bit, 7, 8 or 9 data bits in either order, an optional parity bit, and one or two high stop bits. The baud tick comes from outside as a one-cycle pulse.

The format is held for the whole frame, so software or a neighbouring block may change the control and data inputs as soon as the strobe has been taken. A one-cycle end-of-transfer pulse marks the completion of the final stop bit. Busy is deasserted in that same cycle, and the block can accept the next strobe on the following clock.

Top module: `frame_tx`

## Requirements
- R1: After reset and whenever the block is not busy, `tx_o` is high, `busy_o` is low and `done_o` is low. Ticks that arrive while idle change nothing.
- R2: A `start_i` seen while idle is accepted on that clock edge. From the next cycle `busy_o` is high and `tx_o` is low for the start bit.
- R3: Control bits [1:0] select the data length: 01 gives 9 bits, 10 gives 7 bits, and 11 or 00 give 8 bits. The data is taken from the low bits of `data_i`.
- R4: Control bit [4] selects the data order. A value of 0 sends the most significant active bit first, and 1 sends bit 0 first.
- R5: Control bits [6:5] select the parity. 00 sends no parity bit and 01 sends a constant 0. 10 sends even parity and 11 sends odd parity, both computed over the active data bits only.
- R6: Control bits [3:2] equal to 10 give two high stop bits. Every other code gives one high stop bit.
- R7: Each frame bit stays on `tx_o` until the next tick, and each tick advances the frame by exactly one bit.
- R8: The tick that ends the last stop bit produces `done_o` high for exactly one cycle. In that same cycle `busy_o` falls and `tx_o` returns high.
- R9: While busy, `start_i` is ignored, and changes on `ctrl_i` and `data_i` have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle baud tick |
| start_i | input | 1 | Frame start strobe |
| ctrl_i | input | 7 | Format control word: parity [6:5], order [4], stop [3:2], length [1:0] |
| data_i | input | DATA_W | Parallel data word |
| tx_o | output | 1 | Serial line, high when idle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | End-of-transfer pulse |

## Verification
The bench builds the block with the default DATA_W of 9, the smallest width that holds every length code. Because the control word has only 7 bits, the bench can sweep all 128 format codes. Each code is sent with four data patterns, including all zeros and all ones, so every parity mode meets both parity outcomes. In every frame the bench repeats the strobe and inverts the inputs in the middle of the frame, and it checks each bit on every cycle between ticks, which covers the ignore and hold requirements in all formats.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef struct packed {
    logic [1:0] par;
    logic       lsb_first;
    logic [1:0] stop;
    logic [1:0] len;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } tx_state_e;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_ZERO = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;
  localparam logic [1:0] STOP_TWO = 2'b10;

  function automatic logic [3:0] data_len(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd9;
      2'b10:   return 4'd7;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/frame_tx_parity.sv
module frame_tx_parity
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  output logic              par_o
);
  always_comb begin
    case (mode_i)
      PAR_EVEN: par_o = ^data_i;
      PAR_ODD:  par_o = ~(^data_i);
      default:  par_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/frame_tx_capture.sv
module frame_tx_capture
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  ctrl_t             ctrl_i,
  output ctrl_t             cfg_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o
);
  localparam ctrl_t CFG_RST = '{par: 2'b00, lsb_first: 1'b0, stop: 2'b01, len: 2'b11};

  logic [3:0]        nbits;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] data_m;
  logic              par_d;

  assign nbits = data_len(ctrl_i.len);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(nbits));
  end
  assign data_m = data_i & mask;

  frame_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data_i (data_m),
    .mode_i (ctrl_i.par),
    .par_o  (par_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      data_o <= '0;
      par_o  <= 1'b0;
    end else if (load_i) begin
      cfg_o  <= ctrl_i;
      data_o <= data_m;
      par_o  <= par_d;
    end
  end
endmodule

// File: rtl/frame_tx_bitsel.sv
module frame_tx_bitsel #(
  parameter int DATA_W = 9,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              lsb_first_i,
  output logic              bit_o
);
  logic [CNT_W-1:0] idx;

  assign idx   = lsb_first_i ? cnt_i : (nbits_i - CNT_W'(1) - cnt_i);
  assign bit_o = data_i[idx];
endmodule

// File: rtl/frame_tx_seq.sv
module frame_tx_seq
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             par_en_i,
  input  logic             two_stop_i,
  output logic             load_o,
  output tx_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             done_o
);
  tx_state_e        state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             stop2_q, stop2_d;
  logic             done_d;

  assign busy_o = (state_o != S_IDLE);
  assign load_o = start_i && !busy_o;

  always_comb begin
    state_d = state_o;
    cnt_d   = cnt_o;
    stop2_d = stop2_q;
    done_d  = 1'b0;
    case (state_o)
      S_IDLE:  if (start_i) state_d = S_START;
      S_START: if (tick_i) begin
        state_d = S_DATA;
        cnt_d   = '0;
      end
      S_DATA:  if (tick_i) begin
        if (cnt_o == nbits_i - CNT_W'(1)) begin
          state_d = par_en_i ? S_PAR : S_STOP;
          stop2_d = 1'b0;
        end else begin
          cnt_d = cnt_o + CNT_W'(1);
        end
      end
      S_PAR:   if (tick_i) begin
        state_d = S_STOP;
        stop2_d = 1'b0;
      end
      S_STOP:  if (tick_i) begin
        if (two_stop_i && !stop2_q) begin
          stop2_d = 1'b1;
        end else begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= S_IDLE;
      cnt_o   <= '0;
      stop2_q <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_o <= state_d;
      cnt_o   <= cnt_d;
      stop2_q <= stop2_d;
      done_o  <= done_d;
    end
  end

  assert_done_ends_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_data_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_DATA) |-> (cnt_o < nbits_i));
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int CTRL_W = $bits(ctrl_t)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              done_o
);
  ctrl_t             cfg_q;
  logic [DATA_W-1:0] data_q;
  logic              par_q;
  logic              load;
  tx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nbits;
  logic              data_bit;

  assign nbits = CNT_W'(data_len(cfg_q.len));

  frame_tx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (data_i),
    .ctrl_i (ctrl_t'(ctrl_i)),
    .cfg_o  (cfg_q),
    .data_o (data_q),
    .par_o  (par_q)
  );

  frame_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .start_i    (start_i),
    .nbits_i    (nbits),
    .par_en_i   (cfg_q.par != PAR_NONE),
    .two_stop_i (cfg_q.stop == STOP_TWO),
    .load_o     (load),
    .state_o    (state),
    .cnt_o      (cnt),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  frame_tx_bitsel #(.DATA_W(DATA_W)) u_sel (
    .data_i      (data_q),
    .cnt_i       (cnt),
    .nbits_i     (nbits),
    .lsb_first_i (cfg_q.lsb_first),
    .bit_o       (data_bit)
  );

  always_comb begin
    case (state)
      S_START: tx_o = 1'b0;
      S_DATA:  tx_o = data_bit;
      S_PAR:   tx_o = par_q;
      default: tx_o = 1'b1;
    endcase
  end

  assert_idle_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tx_o));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(tx_o));
  assert_even_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_PAR && cfg_q.par == PAR_EVEN) |-> !(^{data_q, tx_o}));
  assert_cfg_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cfg_q));
endmodule

// File: tb/tb_frame_tx.sv
module tb_frame_tx;
  localparam int DATA_W = 9;
  localparam int K      = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b0;
  logic             start_i = 1'b0;
  logic [6:0]       ctrl_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic             tx_o, busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_tx #(.DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .ctrl_i(ctrl_i), .data_i(data_i), .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [6:0] ctrl, input logic [DATA_W-1:0] data);
    bit exp_bits[16];
    string tags[16];
    int n, nd;
    bit par;
    n = 0;
    nd = (ctrl[1:0] == 2'b01) ? 9 : (ctrl[1:0] == 2'b10) ? 7 : 8;
    exp_bits[n] = 1'b0; tags[n] = "R2 start bit"; n++;
    par = 1'b0;
    for (int i = 0; i < nd; i++) par ^= data[i];
    for (int i = 0; i < nd; i++) begin
      exp_bits[n] = ctrl[4] ? data[i] : data[nd-1-i];
      tags[n] = "R3 R4 R9 data bit";
      n++;
    end
    if (ctrl[6:5] != 2'b00) begin
      exp_bits[n] = (ctrl[6:5] == 2'b01) ? 1'b0 : (ctrl[6:5] == 2'b10) ? par : ~par;
      tags[n] = "R5 parity bit";
      n++;
    end
    exp_bits[n] = 1'b1; tags[n] = "R6 stop bit"; n++;
    if (ctrl[3:2] == 2'b10) begin
      exp_bits[n] = 1'b1; tags[n] = "R6 second stop bit"; n++;
    end
    @(negedge clk);
    start_i = 1'b1; ctrl_i = ctrl; data_i = data;
    @(negedge clk);
    start_i = 1'b0; ctrl_i = ~ctrl; data_i = ~data;
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < K; c++) begin
        chk(tx_o === exp_bits[k], c == 0 ? tags[k] : "R7 bit held", int'(tx_o), int'(exp_bits[k]));
        if (c == 0) chk(busy_o === 1'b1 && done_o === 1'b0, "R2 busy during frame", int'(busy_o), 1);
        if (c == K-1) tick_i = 1'b1;
        if (k == 1 && c == 1) start_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        start_i = 1'b0;
      end
    end
    chk(done_o === 1'b1, "R8 done after last stop", int'(done_o), 1);
    chk(busy_o === 1'b0, "R8 busy falls with done", int'(busy_o), 0);
    chk(tx_o === 1'b1, "R8 line high at done", int'(tx_o), 1);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 done single cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] pats[4];
    pats[0] = 9'h000; pats[1] = 9'h1FF; pats[2] = 9'h0B3; pats[3] = 9'h14C;
    repeat (3) @(negedge clk);
    chk(tx_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
        int'({tx_o, busy_o, done_o}), 4);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      chk(tx_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1 idle tick ignored",
          int'({tx_o, busy_o, done_o}), 4);
    end
    for (int cw = 0; cw < 128; cw++) begin
      for (int p = 0; p < 4; p++) send(7'(cw), pats[p]);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule